// File: doc/BRIEF.md
# Conditional Search Qualifier with Control Register

This block decides whether a device on a multidrop serial bus joins a conditional search round. It holds three small writable registers: a channel-enable mask, a channel-polarity register and a control byte. From these registers, the eight channel pin levels and the eight channel activity flags, it drives one combinational `respond` flag. Each enabled channel compares a source bit with its polarity bit. The source is either the pin or the activity flag, chosen per block. The compare results are then combined by OR or by AND. A power-on flag in the control byte forces `respond` high until software writes a 0 to it.

The block also returns the read value for each byte of an eight-byte register window. The window holds the pin levels, the output-latch value supplied from outside, the activity flags, the three writable registers and two filler bytes. Writes arrive on a synchronous port. Reads are combinational. The search bit protocol and the serial transport sit outside this block. A neighbouring pin driver uses the `strobe_mode` output.

Top module: `cond_search_qual`

## Requirements
- R1: After reset the mask (offset 3, address 008Bh) and the polarity register (offset 4, 008Ch) read 00h. The control byte (offset 5, 008Dh) reads 08h when `supply_present` is 0. `strobe_mode` is 0.
- R2: A write to 008Bh or 008Ch is stored on the clock edge that samples `wr_en` high, and reads back unchanged afterwards.
- R3: The control byte has source select at bit 0, AND mode at bit 1, strobe mode at bit 2 and the power-on flag at bit 3. Bits 0 to 2 are writable. Bits 4 to 6 always read 0. Bit 7 reads the `supply_present` input, and a write to bits 4 to 7 has no effect. `strobe_mode` follows bit 2.
- R4: Writing 0 to control bit 3 clears the power-on flag. Writing 1 to it leaves the flag unchanged. Only reset sets it.
- R5: While the power-on flag is 1, `respond` is 1 whatever the other registers and inputs hold.
- R6: An enabled channel matches when its source bit equals its polarity bit. The source is the pin when control bit 0 is 0 and the activity flag when it is 1.
- R7: With control bit 1 = 0, `respond` is 1 when at least one enabled channel matches.
- R8: With control bit 1 = 1, `respond` is 1 only when every enabled channel matches.
- R9: With a mask of 00h and the power-on flag at 0, `respond` is 0 in both combining modes.
- R10: With exactly one channel enabled, the OR and AND modes give the same `respond`.
- R11: Addresses 0088h, 0089h and 008Ah return `pin_in`, `olat_in` and `act_in`. Writes to these addresses, or to 008Eh and 008Fh, change no register.
- R12: Addresses 008Eh and 008Fh read FFh. Any address outside 0088h–008Fh reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| pin_in | input | 8 | Current channel pin levels |
| act_in | input | 8 | Current channel activity flags |
| olat_in | input | 8 | Output-latch value, returned on reads |
| supply_present | input | 1 | External supply detected |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 16 | Read address |
| rd_data | output | 8 | Read data for rd_addr |
| respond | output | 1 | Join the conditional search |
| strobe_mode | output | 1 | Reset/strobe pin mode bit |

## Verification
The bench targets the empty mask in AND mode. A design that reduces with a plain AND would answer 1 there instead of 0. It also checks a zero polarity bit matching a low source, which catches a design that uses the polarity as a plain enable. It writes 1 to the power-on flag after that flag has been cleared. A design that stores the written bit would set the flag again and force `respond` high. Writes to the read-only and filler addresses, and to the reserved control bits, are followed by read-backs. Those read-backs expose any decode that lets such a write land in a real register.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [2:0] {
    OFS_PIN  = 3'd0,
    OFS_OLAT = 3'd1,
    OFS_ACT  = 3'd2,
    OFS_MASK = 3'd3,
    OFS_POL  = 3'd4,
    OFS_CTRL = 3'd5,
    OFS_PAD0 = 3'd6,
    OFS_PAD1 = 3'd7
  } reg_ofs_e;

  localparam int CB_SRC  = 0;
  localparam int CB_AND  = 1;
  localparam int CB_STRB = 2;
  localparam int CB_POR  = 3;
  localparam int CB_SUP  = 7;

  typedef struct packed {
    logic por;
    logic strobe_mode;
    logic and_mode;
    logic src_latch;
  } ctrl_t;
endpackage

// File: rtl/csq_addr_dec.sv
module csq_addr_dec
  import csq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h88
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_ofs_e          ofs
);
  localparam int OFS_W = 3;

  assign hit = (addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
  assign ofs = reg_ofs_e'(addr[OFS_W-1:0]);
endmodule

// File: rtl/csq_regs.sv
module csq_regs
  import csq_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_hit,
  input  reg_ofs_e       wr_ofs,
  input  logic [NCH-1:0] wr_data,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] pol_q,
  output ctrl_t          ctrl_q
);
  logic wr_mask, wr_pol, wr_ctrl, wr_readonly;

  assign wr_mask     = wr_en && wr_hit && (wr_ofs == OFS_MASK);
  assign wr_pol      = wr_en && wr_hit && (wr_ofs == OFS_POL);
  assign wr_ctrl     = wr_en && wr_hit && (wr_ofs == OFS_CTRL);
  assign wr_readonly = wr_en && !(wr_mask || wr_pol || wr_ctrl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pol_q  <= '0;
      ctrl_q <= '{por: 1'b1, strobe_mode: 1'b0, and_mode: 1'b0, src_latch: 1'b0};
    end else begin
      if (wr_mask) mask_q <= wr_data;
      if (wr_pol)  pol_q  <= wr_data;
      if (wr_ctrl) begin
        ctrl_q.src_latch   <= wr_data[CB_SRC];
        ctrl_q.and_mode    <= wr_data[CB_AND];
        ctrl_q.strobe_mode <= wr_data[CB_STRB];
        // a written 1 keeps the flag as it is; only a 0 clears it
        ctrl_q.por         <= ctrl_q.por & wr_data[CB_POR];
      end
    end
  end

  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(wr_data)));

  assert_pol_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pol |=> (pol_q == $past(wr_data)));

  assert_por_never_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ctrl_q.por));

  assert_readonly_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_readonly |=> ($stable(mask_q) && $stable(pol_q) && $stable(ctrl_q)));
endmodule

// File: rtl/csq_eval.sv
module csq_eval
  import csq_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_in,
  input  logic [NCH-1:0] act_in,
  input  logic [NCH-1:0] mask_q,
  input  logic [NCH-1:0] pol_q,
  input  ctrl_t          ctrl_q,
  output logic           respond
);
  function automatic logic [NCH-1:0] match_vec(input logic [NCH-1:0] src,
                                               input logic [NCH-1:0] pol,
                                               input logic [NCH-1:0] en);
    return ~(src ^ pol) & en;
  endfunction

  function automatic logic all_match(input logic [NCH-1:0] hits,
                                     input logic [NCH-1:0] en);
    return (en != '0) && (hits == en);
  endfunction

  logic [NCH-1:0] src_vec, hit_vec;
  logic any_hit, all_hit, cond_met;

  assign src_vec  = ctrl_q.src_latch ? act_in : pin_in;
  assign hit_vec  = match_vec(src_vec, pol_q, mask_q);
  assign any_hit  = |hit_vec;
  assign all_hit  = all_match(hit_vec, mask_q);
  assign cond_met = ctrl_q.and_mode ? all_hit : any_hit;
  assign respond  = ctrl_q.por | cond_met;

  assert_por_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.por |-> respond);

  assert_empty_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q == '0) && !ctrl_q.por) |-> !respond);

  assert_single_channel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mask_q) == 1) |-> (any_hit == all_hit));
endmodule

// File: rtl/csq_rdmux.sv
module csq_rdmux
  import csq_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic           rd_hit,
  input  reg_ofs_e       rd_ofs,
  input  logic [NCH-1:0] pin_in,
  input  logic [NCH-1:0] olat_in,
  input  logic [NCH-1:0] act_in,
  input  logic [NCH-1:0] mask_q,
  input  logic [NCH-1:0] pol_q,
  input  ctrl_t          ctrl_q,
  input  logic           supply_present,
  output logic [NCH-1:0] rd_data
);
  logic [NCH-1:0] ctrl_byte;

  always_comb begin
    ctrl_byte          = '0;
    ctrl_byte[CB_SRC]  = ctrl_q.src_latch;
    ctrl_byte[CB_AND]  = ctrl_q.and_mode;
    ctrl_byte[CB_STRB] = ctrl_q.strobe_mode;
    ctrl_byte[CB_POR]  = ctrl_q.por;
    ctrl_byte[CB_SUP]  = supply_present;
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit) begin
      unique case (rd_ofs)
        OFS_PIN:  rd_data = pin_in;
        OFS_OLAT: rd_data = olat_in;
        OFS_ACT:  rd_data = act_in;
        OFS_MASK: rd_data = mask_q;
        OFS_POL:  rd_data = pol_q;
        OFS_CTRL: rd_data = ctrl_byte;
        default:  rd_data = '1;
      endcase
    end
  end
endmodule

// File: rtl/cond_search_qual.sv
module cond_search_qual
  import csq_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pin_in,
  input  logic [NCH-1:0]    act_in,
  input  logic [NCH-1:0]    olat_in,
  input  logic              supply_present,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NCH-1:0]    wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NCH-1:0]    rd_data,
  output logic              respond,
  output logic              strobe_mode
);
  logic           wr_hit, rd_hit;
  reg_ofs_e       wr_ofs, rd_ofs;
  logic [NCH-1:0] mask_q, pol_q;
  ctrl_t          ctrl_q;

  csq_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_wr_dec (
    .addr(wr_addr), .hit(wr_hit), .ofs(wr_ofs));

  csq_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_rd_dec (
    .addr(rd_addr), .hit(rd_hit), .ofs(rd_ofs));

  csq_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hit(wr_hit), .wr_ofs(wr_ofs),
    .wr_data(wr_data), .mask_q(mask_q), .pol_q(pol_q), .ctrl_q(ctrl_q));

  csq_eval #(.NCH(NCH)) u_eval (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .act_in(act_in),
    .mask_q(mask_q), .pol_q(pol_q), .ctrl_q(ctrl_q), .respond(respond));

  csq_rdmux #(.NCH(NCH)) u_rdmux (
    .rd_hit(rd_hit), .rd_ofs(rd_ofs), .pin_in(pin_in), .olat_in(olat_in),
    .act_in(act_in), .mask_q(mask_q), .pol_q(pol_q), .ctrl_q(ctrl_q),
    .supply_present(supply_present), .rd_data(rd_data));

  assign strobe_mode = ctrl_q.strobe_mode;
endmodule

// File: tb/cond_search_qual_tb.sv
module cond_search_qual_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_in = '0, act_in = '0, olat_in = '0, wr_data = '0;
  logic        supply_present = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]  rd_data;
  logic        respond, strobe_mode;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_search_qual u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .act_in(act_in), .olat_in(olat_in),
    .supply_present(supply_present), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .respond(respond), .strobe_mode(strobe_mode));

  // {mask, polarity, control, pins, activity, expected respond}
  localparam logic [40:0] VEC [NVEC] = '{
    {8'h01, 8'h01, 8'h00, 8'h01, 8'h00, 1'b1},  // R6 pin high matches pol 1
    {8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0},  // R6 mismatch
    {8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},  // R6 pol 0 matches low
    {8'h03, 8'h03, 8'h00, 8'h01, 8'h00, 1'b1},  // R7 one of two
    {8'h03, 8'h03, 8'h02, 8'h01, 8'h00, 1'b0},  // R8 one of two
    {8'h03, 8'h03, 8'h02, 8'h03, 8'h00, 1'b1},  // R8 both
    {8'h80, 8'h80, 8'h01, 8'h80, 8'h00, 1'b0},  // R6 latch source ignores pin
    {8'h80, 8'h80, 8'h01, 8'h00, 8'h80, 1'b1},  // R6 latch source
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},  // R9 OR empty
    {8'h00, 8'h00, 8'h02, 8'h00, 8'h00, 1'b0},  // R9 AND empty
    {8'h10, 8'h00, 8'h02, 8'h00, 8'h00, 1'b1},  // R10 AND single
    {8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},  // R10 OR single
    {8'h10, 8'h00, 8'h02, 8'h10, 8'h00, 1'b0},  // R10 AND single miss
    {8'hF0, 8'hA0, 8'h03, 8'h00, 8'hA5, 1'b1},  // R8 latch AND all
    {8'hF0, 8'hA0, 8'h03, 8'hA0, 8'h25, 1'b0},  // R8 latch AND one off
    {8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0}   // R7 none match
  };

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(16'h008B, d); check("R1 mask", d, 8'h00);
    rd(16'h008C, d); check("R1 pol", d, 8'h00);
    rd(16'h008D, d); check("R1 ctrl", d, 8'h08);
    check("R1 strobe_mode", {7'd0, strobe_mode}, 8'h00);
    check("R5 por forces", {7'd0, respond}, 8'h01);
    supply_present = 1'b1;
    rd(16'h008D, d); check("R3 supply bit", d, 8'h88);
    supply_present = 1'b0;

    // control byte and power-on flag
    wr(16'h008D, 8'h0C);
    rd(16'h008D, d); check("R4 write 1 keeps por", d, 8'h0C);
    check("R3 strobe_mode", {7'd0, strobe_mode}, 8'h01);
    wr(16'h008D, 8'hF8);
    rd(16'h008D, d); check("R3 bits 4-7 ignored", d, 8'h08);
    wr(16'h008D, 8'h00);
    rd(16'h008D, d); check("R4 write 0 clears", d, 8'h00);
    check("R9 empty mask after clear", {7'd0, respond}, 8'h00);
    wr(16'h008D, 8'h08);
    rd(16'h008D, d); check("R4 write 1 no set", d, 8'h00);
    check("R4 respond stays 0", {7'd0, respond}, 8'h00);

    // writable registers
    wr(16'h008B, 8'h5A);
    rd(16'h008B, d); check("R2 mask", d, 8'h5A);
    wr(16'h008C, 8'hC3);
    rd(16'h008C, d); check("R2 pol", d, 8'hC3);

    // read-only and filler window
    pin_in = 8'h3C; act_in = 8'h81; olat_in = 8'h7E;
    rd(16'h0088, d); check("R11 pins", d, 8'h3C);
    rd(16'h0089, d); check("R11 out latch", d, 8'h7E);
    rd(16'h008A, d); check("R11 activity", d, 8'h81);
    wr(16'h0088, 8'hFF); wr(16'h0089, 8'h00); wr(16'h008A, 8'h00);
    wr(16'h008E, 8'h00); wr(16'h008F, 8'h0F);
    rd(16'h008B, d); check("R11 mask untouched", d, 8'h5A);
    rd(16'h008C, d); check("R11 pol untouched", d, 8'hC3);
    rd(16'h008D, d); check("R11 ctrl untouched", d, 8'h00);
    rd(16'h0088, d); check("R11 pins after write", d, 8'h3C);
    rd(16'h008E, d); check("R12 pad E", d, 8'hFF);
    rd(16'h008F, d); check("R12 pad F", d, 8'hFF);
    rd(16'h0087, d); check("R12 below window", d, 8'h00);
    rd(16'h0090, d); check("R12 above window", d, 8'h00);
    wr(16'h0093, 8'h11);
    rd(16'h008B, d); check("R12 outside write ignored", d, 8'h5A);

    // qualification table
    for (int i = 0; i < NVEC; i++) begin
      wr(16'h008B, VEC[i][40:33]);
      wr(16'h008C, VEC[i][32:25]);
      wr(16'h008D, VEC[i][24:17]);
      pin_in = VEC[i][16:9];
      act_in = VEC[i][8:1];
      #1;
      check($sformatf("R6/R7/R8/R9/R10 vector %0d", i), {7'd0, respond}, {7'd0, VEC[i][0]});
    end

    // power-on flag overrides a failing match
    pin_in = 8'hFF;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    wr(16'h008B, 8'hFF);
    #1;
    check("R5 por overrides mismatch", {7'd0, respond}, 8'h01);

    report();
    $finish;
  end
endmodule